// File: doc/BRIEF.md
# Truncated-Cycle LFSR Counter

This block is a compact modulo-m counter built from an n-bit shift register. On each enabled clock the register moves one place toward its most significant bit, and a new least significant bit is shifted in. That bit is the XNOR of the two highest bits. Left alone, this feedback walks through a long sequence. One decoded state complements the shifted-in bit, and this folds the walk into a shorter loop of a chosen length m. The skip state, the terminal state and the reset value are parameters. The block does not search for them.

A single comparator on the state raises a terminal flag, which marks the last count of the loop. The counter can be used as a small divider or as a timeout. The register is cheap and has almost no carry logic. A zero reset may begin outside the short loop, and in that case the counter spends a few counts before it joins the loop. To avoid that entry delay, give the reset-value parameter a state that lies inside the loop.

With the default settings (4 bits, skip state 9, terminal state 9, reset value 0) the loop is 3, 7, E, D, B, 6, C, 9, and then it returns to 3.

Top module: `tlc_counter`

## Requirements
- R1: A synchronous reset (`rst_i` high at a rising edge) loads `RESET_VALUE` into `count_o`, whatever `en_i` is. While `rst_i` is high, `term_o` is low.
- R2: When `en_i` is low and `rst_i` is low, `count_o` keeps its value across the edge and `term_o` is low.
- R3: On an enabled edge, bits [WIDTH-1:1] of the new count equal bits [WIDTH-2:0] of the old count. When the old count is not `SKIP_STATE`, the new bit 0 is 1 exactly when the old bits WIDTH-1 and WIDTH-2 are equal.
- R4: On an enabled edge from `SKIP_STATE`, the new bit 0 is the complement of the value that R3 gives. With the defaults, the state after 9 is 3 and not 2.
- R5: With the defaults and reset to 0, continuous enable gives 0, 1, 3, 7, E, D, B, 6, C, 9. State 3 appears after 2 edges, and state 9 first appears after 9 edges.
- R6: `term_o` is high in a cycle exactly when `rst_i` is low, `en_i` is high and `count_o` equals `TERM_STATE`.
- R7: When `RESET_VALUE` lies inside the loop, the counter is in the loop at once. With WIDTH 6, `SKIP_STATE` 2D, `TERM_STATE` 2D and `RESET_VALUE` 1B, the sequence is 1B, 36, 2D, 1B, and so on.
- R8: Once the counter is in its loop, any run of 24 consecutive enabled cycles contains exactly 24/m terminal pulses: 3 for the default 8-loop and 8 for the 6-bit 3-loop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high; loads `RESET_VALUE` |
| en_i | input | 1 | Advance enable; when low the count holds |
| count_o | output | WIDTH | Current shift-register state |
| term_o | output | 1 | High while enabled and the count is at the terminal state |

## Verification
A wrong feedback tap or a missed skip decode shows up on `count_o` at the very next enabled edge. The new bit 0 differs from the expected value, and the whole sequence then leaves the short loop. A terminal decode on the wrong state changes `term_o` in the same cycle as the count that matches it. A broken hold path shows after the first idle edge. A wrong reset value shows on the edge that follows the reset.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  // Feedback bit made of two parts: the raw tap result and the skip flip.
  typedef struct packed {
    logic raw;
    logic flip;
  } tlc_fb_t;

  // Equality of the two top bits (XNOR).
  function automatic logic tlc_tap_xnor(input logic hi, input logic lo);
    return ~(hi ^ lo);
  endfunction

  // Bit that is shifted in.
  function automatic logic tlc_fb_bit(input tlc_fb_t f);
    return f.raw ^ f.flip;
  endfunction

endpackage

// File: rtl/tlc_feedback.sv
module tlc_feedback #(
  parameter int unsigned WIDTH = 4,
  parameter logic [WIDTH-1:0] SKIP_STATE = 'h9
) (
  input  logic [WIDTH-1:0] state_i,
  output logic             fb_o,
  output logic             skip_hit_o
);
  import tlc_pkg::*;

  localparam int unsigned TAP_HI = WIDTH - 1;
  localparam int unsigned TAP_LO = WIDTH - 2;

  tlc_fb_t fb;

  always_comb begin
    skip_hit_o = (state_i == SKIP_STATE);
    fb.raw     = tlc_tap_xnor(state_i[TAP_HI], state_i[TAP_LO]);
    fb.flip    = skip_hit_o;
    fb_o       = tlc_fb_bit(fb);
  end
endmodule

// File: rtl/tlc_state_reg.sv
module tlc_state_reg #(
  parameter int unsigned WIDTH = 4,
  parameter logic [WIDTH-1:0] RESET_VALUE = '0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             step_i,
  input  logic             fb_i,
  output logic [WIDTH-1:0] state_o
);
  logic [WIDTH-1:0] state_d;

  always_comb begin
    if (step_i) state_d = {state_o[WIDTH-2:0], fb_i};
    else        state_d = state_o;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) state_o <= RESET_VALUE;
    else       state_o <= state_d;
  end
endmodule

// File: rtl/tlc_term_detect.sv
module tlc_term_detect #(
  parameter int unsigned WIDTH = 4,
  parameter logic [WIDTH-1:0] TERM_STATE = 'h9
) (
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [WIDTH-1:0] state_i,
  output logic             term_o
);
  logic at_term;

  always_comb begin
    at_term = (state_i == TERM_STATE);
    term_o  = at_term & en_i & ~rst_i;
  end
endmodule

// File: rtl/tlc_counter.sv
module tlc_counter #(
  parameter int unsigned WIDTH = 4,
  parameter logic [WIDTH-1:0] SKIP_STATE  = 'h9,
  parameter logic [WIDTH-1:0] TERM_STATE  = 'h9,
  parameter logic [WIDTH-1:0] RESET_VALUE = '0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] count_o,
  output logic             term_o
);
  // Internal events, brought out by name for the checker.
  logic fb_bit;
  logic skip_hit;
  logic step_en;

  assign step_en = en_i;

  tlc_feedback #(
    .WIDTH      (WIDTH),
    .SKIP_STATE (SKIP_STATE)
  ) u_feedback (
    .state_i    (count_o),
    .fb_o       (fb_bit),
    .skip_hit_o (skip_hit)
  );

  tlc_state_reg #(
    .WIDTH       (WIDTH),
    .RESET_VALUE (RESET_VALUE)
  ) u_state (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .step_i  (step_en),
    .fb_i    (fb_bit),
    .state_o (count_o)
  );

  tlc_term_detect #(
    .WIDTH      (WIDTH),
    .TERM_STATE (TERM_STATE)
  ) u_term (
    .rst_i   (rst_i),
    .en_i    (en_i),
    .state_i (count_o),
    .term_o  (term_o)
  );
endmodule

// File: rtl/tlc_counter_chk.sv
module tlc_counter_chk #(
  parameter int unsigned WIDTH = 4,
  parameter logic [WIDTH-1:0] SKIP_STATE  = 'h9,
  parameter logic [WIDTH-1:0] TERM_STATE  = 'h9,
  parameter logic [WIDTH-1:0] RESET_VALUE = '0
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             en_i,
  input logic [WIDTH-1:0] count_o,
  input logic             term_o,
  input logic             skip_hit,
  input logic             step_en
);
  AST_RESET_LOAD: assert property (@(posedge clk_i) rst_i |=> count_o == RESET_VALUE); // R1
  AST_RESET_NO_TERM: assert property (@(posedge clk_i) rst_i |-> !term_o); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(count_o)); // R2
  AST_IDLE_NO_TERM: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |-> !term_o && !step_en); // R2
  AST_SHIFT_UP: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |=> count_o[WIDTH-1:1] == $past(count_o[WIDTH-2:0])); // R3
  AST_RAW_FEEDBACK: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i && !skip_hit |=> count_o[0] == ($past(count_o[WIDTH-1]) == $past(count_o[WIDTH-2]))); // R3
  AST_SKIP_FLIP: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i && skip_hit |=> count_o[0] == ($past(count_o[WIDTH-1]) != $past(count_o[WIDTH-2]))); // R4
  AST_SKIP_DECODE: assert property (@(posedge clk_i) disable iff (rst_i)
    skip_hit |-> count_o == SKIP_STATE); // R4
  AST_TERM_ONLY_AT_END: assert property (@(posedge clk_i) disable iff (rst_i)
    term_o |-> en_i && count_o == TERM_STATE); // R6
  AST_TERM_NOT_MISSED: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i && count_o == TERM_STATE |-> term_o); // R6
endmodule

bind tlc_counter tlc_counter_chk #(
  .WIDTH       (WIDTH),
  .SKIP_STATE  (SKIP_STATE),
  .TERM_STATE  (TERM_STATE),
  .RESET_VALUE (RESET_VALUE)
) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .en_i     (en_i),
  .count_o  (count_o),
  .term_o   (term_o),
  .skip_hit (skip_hit),
  .step_en  (step_en)
);

// File: tb/test_tlc_counter.sv
`timescale 1ns/1ps
module test_tlc_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [3:0] count4;
  logic [5:0] count6;
  logic term4, term6;

  int checks   = 0;
  int failures = 0;
  logic [7:0] m4 = 8'h00;
  logic [7:0] m6 = 8'h1B;

  always #2.5 clk = ~clk;

  tlc_counter i_tlc_counter (
    .clk_i(clk), .rst_i(rst), .en_i(en), .count_o(count4), .term_o(term4)
  );

  tlc_counter #(
    .WIDTH(6), .SKIP_STATE(6'h2D), .TERM_STATE(6'h2D), .RESET_VALUE(6'h1B)
  ) i_tlc_counter_m3 (
    .clk_i(clk), .rst_i(rst), .en_i(en), .count_o(count6), .term_o(term6)
  );

  // Next state, written as shift-and-OR of a mask plus an equality test.
  function automatic logic [7:0] mdl_next(input logic [7:0] s, input int w, input logic [7:0] skip);
    logic [7:0] mask;
    logic nb;
    mask = 8'((9'd1 << w) - 9'd1);
    nb = (s[w-1] == s[w-2]);
    if (s == skip) nb = ~nb;
    return ((s << 1) & mask) | {7'd0, nb};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, check term before the rise, count after it.
  task automatic cyc(input logic r, input logic e, input string req, output logic t4, output logic t6);
    @(negedge clk);
    rst = r;
    en  = e;
    #1;
    t4 = term4;
    t6 = term6;
    check("R6", "term4", int'(term4), int'(!r && e && m4 == 8'h09));
    check("R6", "term6", int'(term6), int'(!r && e && m6 == 8'h2D));
    @(posedge clk);
    if (r) begin
      m4 = 8'h00;
      m6 = 8'h1B;
    end else if (e) begin
      m4 = mdl_next(m4, 4, 8'h09);
      m6 = mdl_next(m6, 6, 8'h2D);
    end
    #1;
    check(req, "count4", int'(count4), int'(m4));
    check(req, "count6", int'(count6), int'(m6));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic t4, t6;
    int p4, p6;
    void'($urandom(32'd4242));
    // R1: reset state of both counters
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, "R1", t4, t6);
    check("R1", "reset count4", int'(count4), 0);
    check("R1", "reset count6", int'(count6), 'h1B);

    // R5, R4, R7, R8: directed run with continuous enable
    p4 = 0;
    p6 = 0;
    for (int k = 1; k <= 33; k++) begin
      cyc(1'b0, 1'b1, "R3", t4, t6);
      if (k >= 10) begin
        p4 += int'(t4);
        p6 += int'(t6);
      end
      if (k == 2)  check("R5", "entry to 3", int'(count4), 'h3);
      if (k == 9)  check("R5", "first 9", int'(count4), 'h9);
      if (k == 10) check("R4", "after skip", int'(count4), 'h3);
      if (k == 1)  check("R7", "m3 step1", int'(count6), 'h36);
      if (k == 2)  check("R7", "m3 step2", int'(count6), 'h2D);
      if (k == 3)  check("R7", "m3 step3", int'(count6), 'h1B);
    end
    check("R8", "term pulses 8-loop", p4, 3);
    check("R8", "term pulses 3-loop", p6, 8);

    // R2: hold with enable low
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, "R2", t4, t6);

    // R1: reset wins over enable
    cyc(1'b1, 1'b1, "R1", t4, t6);
    check("R1", "reset with enable", int'(count4), 0);

    // Random mix of enable and occasional reset
    for (int i = 0; i < 600; i++) begin
      logic r, e;
      r = ($urandom % 40) == 0;
      e = ($urandom % 4) != 0;
      cyc(r, e, e ? "R3" : "R2", t4, t6);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule